// File: doc/BRIEF.md
# Multiplexed Four-Digit Display Scanner

The block drives a four-digit seven-segment display through a single shared segment decoder. It lights one digit position at a time and steps through all four positions fast enough that the eye sees all of them lit together. A prescaler divides the system clock into a scan tick of roughly 1 kHz (a ratio of 16000 from a 16 MHz clock). Each tick steps a 2-bit position index. The index does two jobs: it picks one of the four BCD inputs to feed the decoder, and it selects which digit enable is active. One full pass over the display takes about four scan periods.

The segment lines and the digit enables both come from registers that load on the same clock edge. When the position changes, the new enable and the new segment pattern therefore appear together, and no digit briefly shows its neighbour's pattern. Two parameters set the active level of the segment lines and of the digit enables, so the block can drive common-anode or common-cathode parts without extra glue logic.

Top module: `disp_scan`

## Requirements
- R1: While reset (rst_n low) is asserted, every segment line and every digit enable sits at its inactive level. The position index returns to 0 and the prescaler restarts from zero.
- R2: The position index advances by one, wrapping from 3 to 0, exactly once every TICK_DIV clock cycles. The first advance comes TICK_DIV cycles after reset is released.
- R3: From the first clock edge after reset, exactly one digit enable is active at a time.
- R4: When the position index is k, digit enable k (en_o bit k) is the active one. The segments show BCD digit k, which is bcd_i bits 4k+3 down to 4k. Positions run in the order 0, 1, 2, 3, 0.
- R5: Segment bit 0 is segment a and bit 6 is segment g. In active-high form, digits 0 through 9 give the patterns 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R6: A selected BCD value from 10 to 15 turns every segment off.
- R7: If SEG_ACT_HIGH is 0, every segment line is inverted. If EN_ACT_HIGH is 0, every digit enable is inverted.
- R8: Segment lines and digit enables are registered. They change on the same edge, one clock after the position index changes.
- R9: A change on bcd_i for the digit currently shown appears on the segment lines one clock later. No scan tick is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_i | input | 16 | Four BCD digits; digit k in bits 4k+3:4k |
| seg_o | output | 7 | Shared segment lines a..g on bits 0..6 |
| en_o | output | 4 | Digit enables, one per position |

## Verification
The bench builds two copies of the block. The first uses TICK_DIV=5 and active-high outputs. The second uses TICK_DIV=3 and active-low outputs. These short prescaler ratios let many full scan passes, wraps of the index and prescaler restarts fit into a few hundred cycles. The second copy also checks the inverted polarity on both output groups. The patterns applied to bcd_i cover every value from 0 to 15, mid-scan changes to the digit on display, and a reset applied in the middle of a scan.

// File: rtl/disp_scan.sv
module disp_scan #(
  parameter int unsigned TICK_DIV     = 16000,
  parameter bit          SEG_ACT_HIGH = 1'b1,
  parameter bit          EN_ACT_HIGH  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bcd_i,
  output logic [6:0]  seg_o,
  output logic [3:0]  en_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre;
  logic [1:0]    idx;
  logic          tick;
  logic [3:0]    cur;
  logic [6:0]    pat, seg_q;
  logic [3:0]    en_q;

  assign tick = (pre == PRE_LAST);
  assign cur  = bcd_i[{idx, 2'b00} +: 4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0;
      idx <= 2'd0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) idx <= idx + 2'd1;
    end

  always_comb
    case (cur)
      4'd0: pat = 7'h3F;
      4'd1: pat = 7'h06;
      4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F;
      4'd4: pat = 7'h66;
      4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D;
      4'd7: pat = 7'h07;
      4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F;
      default: pat = 7'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seg_q <= 7'h00;
      en_q  <= 4'h0;
    end else begin
      seg_q <= pat;
      en_q  <= 4'b0001 << idx;
    end

  assign seg_o = seg_q ^ {7{~SEG_ACT_HIGH}};
  assign en_o  = en_q  ^ {4{~EN_ACT_HIGH}};

  p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= PRE_LAST);
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> idx == $past(idx) + 2'd1);
  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> idx == $past(idx));
  p_one_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $countones(en_q) == 1);
  p_en_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> en_q == (4'b0001 << $past(idx)));
  p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur > 4'd9) |=> seg_q == 7'h00);
endmodule

// File: tb/sim_disp_scan.sv
module sim_disp_scan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bcd = 16'h0000;
  logic [6:0]  seg0, seg1;
  logic [3:0]  en0, en1;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  disp_scan #(.TICK_DIV(5), .SEG_ACT_HIGH(1'b1), .EN_ACT_HIGH(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bcd_i(bcd), .seg_o(seg0), .en_o(en0));
  disp_scan #(.TICK_DIV(3), .SEG_ACT_HIGH(1'b0), .EN_ACT_HIGH(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bcd_i(bcd), .seg_o(seg1), .en_o(en1));

  function automatic logic [6:0] glyph(input int v);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (v < 10) ? t[v] : 7'h00;
  endfunction

  int m_cnt [2];
  int m_pos [2];
  int m_div [2] = '{5, 3};
  logic [6:0] x_seg [2];
  logic [3:0] x_en  [2];
  int x_val [2];
  bit x_rst;

  always @(posedge clk or negedge rst_n)
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_cnt[i] <= 0; m_pos[i] <= 0;
        x_seg[i] <= 7'h00; x_en[i] <= 4'h0; x_val[i] <= 0; x_rst <= 1'b1;
      end else begin
        x_val[i] <= (bcd >> (4 * m_pos[i])) & 15;
        x_seg[i] <= glyph((bcd >> (4 * m_pos[i])) & 15);
        x_en[i]  <= 4'(1 << m_pos[i]);
        x_rst    <= 1'b0;
        if (m_cnt[i] == m_div[i] - 1) begin
          m_cnt[i] <= 0;
          m_pos[i] <= (m_pos[i] + 1) % 4;
        end else m_cnt[i] <= m_cnt[i] + 1;
      end
    end

  task automatic check_one(input int i, input logic [6:0] s, input logic [3:0] e);
    logic [6:0] es = (i == 1) ? ~x_seg[i] : x_seg[i];
    logic [3:0] ee = (i == 1) ? ~x_en[i]  : x_en[i];
    string req;
    compared++;
    if (s !== es || e !== ee) begin
      mismatched++;
      if (x_rst) req = "R1";
      else if (e !== ee) req = (i == 1) ? "R7 (enable polarity) / R4" : "R4 / R2 / R3";
      else if (x_val[i] > 9) req = "R6";
      else req = (i == 1) ? "R7 (segment polarity) / R5" : "R5 / R9";
      $display("FAIL %s u%0d: seg=%h en=%b expected seg=%h en=%b at %0t",
               req, i, s, e, es, ee, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      check_one(0, seg0, en0);
      check_one(1, seg1, en1);
    end
  end

  task automatic run(input logic [15:0] v, input int n);
    @(negedge clk); bcd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);      // R1: outputs inactive while held in reset
    rst_n = 1'b1;
    run(16'h3210, 60);              // R2 R3 R4 R5: scan order and patterns
    run(16'h7654, 60);              // R5 R8
    run(16'hBA98, 60);              // R5 R6
    run(16'hFEDC, 60);              // R6 R7 on the active-low copy
    for (int k = 0; k < 40; k++)    // R9: digits change between scan ticks
      run(16'($urandom), 1 + (k % 7));
    @(negedge clk); rst_n = 1'b0;   // R1: reset in the middle of a scan
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run(16'h9A05, 80);              // R1 R2: prescaler restarted from zero
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not end, actual running expected stopped");
    finish_up();
  end
endmodule